// File: doc/BRIEF.md
# Freewheeling Full-Bridge Drive Controller

This block turns a digital resonant phase reference into the four gate-driver commands of a full bridge. There are two driver pairs, each feeding one gate-drive transformer: the upper pair for one half-bridge and the lower pair for the other. In normal drive the two half-bridges switch in antiphase. A burst-enable input gates the drive, and an over-current compare flag changes the drive mode. On an over-current the bridge does not shut down. For one phase period, one pair is retimed into phase with the other, so the bridge freewheels. An under-voltage flag forces the drive off at once.

Every decision is taken at a rising edge of the phase reference, which approximates zero-current switching. These decisions are starting drive, stopping drive and entering or leaving freewheel. Mode selects come only from registers that update on those edges. The delayed phase itself passes straight through a select stage to the outputs, so a mode change never leaves a partial-cycle sliver on a driver input. The phase, burst and over-current inputs are synchronized to the controller clock. The under-voltage flag acts asynchronously.

Top module: `fwb_drive_ctrl`

## Requirements
- R1: While reset is asserted (and after it, until a burst starts), all four driver commands are low.
- R2: While drive is disabled, all four driver commands are low, whatever the phase and over-current inputs do.
- R3: In normal drive, drv_ua equals the phase and drv_ub its inverse, while drv_la equals the inverse of the phase and drv_lb the phase. The two half-bridges run in antiphase.
- R4: Drive starts at the first rising phase edge after burst_in rises. It stops at the first rising phase edge after burst_in falls, even while freewheeling, and no in-phase toggling follows that edge.
- R5: An over-current pulse of at least two clocks is held until the next rising phase edge and does not change the current period. It puts the bridge into freewheel for exactly one phase period starting at that edge. The hold is cleared at that edge.
- R6: In freewheel one pair is inverted, so drv_ua equals drv_la and drv_ub equals drv_lb. With ALT_LEG=1 the inverted pair alternates on each freewheel event, starting with the lower pair after reset. With ALT_LEG=0 the lower pair is always the one inverted.
- R7: The rising phase edge that starts a burst presets the mode to normal drive. An over-current pending at that edge is discarded and does not advance the leg alternation.
- R8: uv_in high forces all four commands low at once, without waiting for a clock. This clear overrides a burst start, and drive stays off until burst_in rises again after uv_in has been released.
- R9: Outputs follow phase_in SYNC_STAGES+1 clocks later. The enable and the mode selects change only on the clock that also moves the delayed phase.
- R10: While any command is high, each pair is complementary: exactly one of drv_ua/drv_ub and exactly one of drv_la/drv_lb is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 1 | Resonant phase reference (square wave) |
| burst_in | input | 1 | Burst enable, high to request drive |
| oc_in | input | 1 | Over-current compare flag, high on an event |
| uv_in | input | 1 | Under-voltage flag, asynchronous, high forces drive off |
| drv_ua | output | 1 | Upper pair, transformer input A |
| drv_ub | output | 1 | Upper pair, transformer input B |
| drv_la | output | 1 | Lower pair, transformer input A |
| drv_lb | output | 1 | Lower pair, transformer input B |

## Verification
The assertions check, on every clock, the properties that are local in time. Outputs are quiet while drive is disabled or under-voltage is high, and each active pair stays complementary. The enable and selects move only after a detected phase rise, the over-current hold is empty after each rise, and a freewheeling bridge has both legs in phase. The bench scenarios are needed for sequences that span whole phase periods. These are the exact period in which drive starts and stops, the single-period freewheel and its leg alternation, the discarding of an over-current at burst start, and the rule that drive stays off after an under-voltage until the next burst.

// File: rtl/fwb_pkg.sv
// Package: shared types and constants for the freewheeling bridge controller.
// Assumes: the synchronized input bus carries phase, burst and over-current.
package fwb_pkg;

    // Bit positions inside the synchronized input bus.
    localparam int IDX_PHASE = 0;
    localparam int IDX_BURST = 1;
    localparam int IDX_OC    = 2;
    localparam int SYNC_W    = 3;

    // Which pair is inverted for a freewheel period.
    typedef enum logic {
        LEG_LOWER = 1'b0,
        LEG_UPPER = 1'b1
    } fwb_leg_e;

    // The four driver commands, two per gate-drive transformer.
    typedef struct packed {
        logic ua;
        logic ub;
        logic la;
        logic lb;
    } fwb_gate_t;

endpackage

// File: rtl/fwb_sync.sv
// Module: multi-bit, multi-stage input synchronizer.
// Assumes: each input bit is independent and held for at least two clocks.
module fwb_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw inputs.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= d;
                end
            end else begin : g_next
                // Shift through the remaining stages.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= '0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/fwb_enable.sv
// Module: burst enable aligned to rising phase edges, with an asynchronous
// under-voltage clear that beats every set.
// Assumes: burst_s is synchronized; uv_in is a raw level.
module fwb_enable (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_in,
    input  logic burst_s,
    input  logic phase_rise,
    output logic en_q
);

    logic burst_d;
    logic armed_q;
    logic burst_rise;

    assign burst_rise = burst_s & ~burst_d;

    // Delay the synchronized burst to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) burst_d <= 1'b0;
        else        burst_d <= burst_s;
    end

    // Arm on a burst rise; drop on burst low or under-voltage.
    always_ff @(posedge clk or posedge uv_in) begin
        if (uv_in)           armed_q <= 1'b0;
        else if (!rst_n)     armed_q <= 1'b0;
        else if (!burst_s)   armed_q <= 1'b0;
        else if (burst_rise) armed_q <= 1'b1;
    end

    // Take the armed state into the enable only on a rising phase edge.
    always_ff @(posedge clk or posedge uv_in) begin
        if (uv_in)           en_q <= 1'b0;
        else if (!rst_n)     en_q <= 1'b0;
        else if (phase_rise) en_q <= armed_q;
    end

endmodule

// File: rtl/fwb_mode.sv
// Module: over-current hold, freewheel decision and leg alternation.
// Assumes: oc_s is synchronized; en_q is the enable before the current edge,
// so the edge that starts a burst always presets normal drive.
module fwb_mode
    import fwb_pkg::*;
#(
    parameter bit ALT_LEG = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_rise,
    input  logic oc_s,
    input  logic en_q,
    output logic oc_hold_q,
    output logic sel_lo_q,
    output logic sel_hi_q
);

    logic     pending;
    logic     fire;
    fwb_leg_e next_leg;

    assign pending = oc_hold_q | oc_s;
    assign fire    = phase_rise & en_q & pending;

    // Hold an over-current until the rising phase edge that consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)          oc_hold_q <= 1'b0;
        else if (phase_rise) oc_hold_q <= 1'b0;
        else if (oc_s)       oc_hold_q <= 1'b1;
    end

    generate
        if (ALT_LEG) begin : g_alt
            fwb_leg_e leg_q;
            // Remember the last inverted leg; start so the lower leg goes first.
            always_ff @(posedge clk) begin
                if (!rst_n)    leg_q <= LEG_UPPER;
                else if (fire) leg_q <= fwb_leg_e'(~leg_q);
            end
            assign next_leg = fwb_leg_e'(~leg_q);
        end else begin : g_fixed
            assign next_leg = LEG_LOWER;
        end
    endgenerate

    // Registered selects, updated only on rising phase edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_lo_q <= 1'b0;
            sel_hi_q <= 1'b0;
        end else if (phase_rise) begin
            sel_lo_q <= fire & (next_leg == LEG_LOWER);
            sel_hi_q <= fire & (next_leg == LEG_UPPER);
        end
    end

endmodule

// File: rtl/fwb_outstage.sv
// Module: select-style output stage. The phase passes straight through;
// only the registered selects and enable pick its polarity per pair.
// Assumes: all control inputs are register outputs.
module fwb_outstage
    import fwb_pkg::*;
(
    input  logic      phase_d,
    input  logic      en_q,
    input  logic      sel_lo_q,
    input  logic      sel_hi_q,
    output fwb_gate_t gate
);

    logic up_a;
    logic lo_a;

    // Pick each pair's polarity, then gate everything with the enable.
    always_comb begin
        up_a    = sel_hi_q ? ~phase_d :  phase_d;
        lo_a    = sel_lo_q ?  phase_d : ~phase_d;
        gate.ua = en_q &  up_a;
        gate.ub = en_q & ~up_a;
        gate.la = en_q &  lo_a;
        gate.lb = en_q & ~lo_a;
    end

endmodule

// File: rtl/fwb_drive_ctrl.sv
// Module: top of the freewheeling full-bridge drive controller.
// Assumes: phase_in is a square wave with half periods well above
// SYNC_STAGES+1 clocks; uv_in may change at any time.
module fwb_drive_ctrl
    import fwb_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit ALT_LEG     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phase_in,
    input  logic burst_in,
    input  logic oc_in,
    input  logic uv_in,
    output logic drv_ua,
    output logic drv_ub,
    output logic drv_la,
    output logic drv_lb
);

    logic [SYNC_W-1:0] raw_bus;
    logic [SYNC_W-1:0] sync_bus;
    logic              phase_q;
    logic              phase_d;
    logic              phase_rise;
    logic              en_q;
    logic              oc_hold_q;
    logic              sel_lo_q;
    logic              sel_hi_q;
    fwb_gate_t         gate;

    always_comb begin
        raw_bus            = '0;
        raw_bus[IDX_PHASE] = phase_in;
        raw_bus[IDX_BURST] = burst_in;
        raw_bus[IDX_OC]    = oc_in;
    end

    fwb_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_bus),
        .q     (sync_bus)
    );

    assign phase_q    = sync_bus[IDX_PHASE];
    assign phase_rise = phase_q & ~phase_d;

    // Delay the phase one clock so it moves together with the selects.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_d <= 1'b0;
        else        phase_d <= phase_q;
    end

    fwb_enable u_enable (
        .clk        (clk),
        .rst_n      (rst_n),
        .uv_in      (uv_in),
        .burst_s    (sync_bus[IDX_BURST]),
        .phase_rise (phase_rise),
        .en_q       (en_q)
    );

    fwb_mode #(.ALT_LEG(ALT_LEG)) u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_rise (phase_rise),
        .oc_s       (sync_bus[IDX_OC]),
        .en_q       (en_q),
        .oc_hold_q  (oc_hold_q),
        .sel_lo_q   (sel_lo_q),
        .sel_hi_q   (sel_hi_q)
    );

    fwb_outstage u_out (
        .phase_d  (phase_d),
        .en_q     (en_q),
        .sel_lo_q (sel_lo_q),
        .sel_hi_q (sel_hi_q),
        .gate     (gate)
    );

    assign drv_ua = gate.ua;
    assign drv_ub = gate.ub;
    assign drv_la = gate.la;
    assign drv_lb = gate.lb;

endmodule

// File: rtl/fwb_drive_ctrl_chk.sv
// Module: assertion checker for fwb_drive_ctrl, bound to every instance.
// Assumes: reset is held for at least one clock at start-up.
module fwb_drive_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic uv_in,
    input logic phase_rise,
    input logic en_q,
    input logic oc_hold_q,
    input logic sel_lo_q,
    input logic sel_hi_q,
    input logic drv_ua,
    input logic drv_ub,
    input logic drv_la,
    input logic drv_lb
);

    logic any_on;
    assign any_on = drv_ua | drv_ub | drv_la | drv_lb;

    // R2
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !any_on);

    // R8
    uv_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uv_in |-> !any_on);

    // R10
    pair_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_on |-> ((drv_ua ^ drv_ub) && (drv_la ^ drv_lb)));

    // R9
    sel_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sel_lo_q) || !$stable(sel_hi_q)) |-> $past(phase_rise));

    // R4
    en_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_q) |-> $past(phase_rise));

    // R5
    hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phase_rise) |-> !oc_hold_q);

    // R6
    one_leg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo_q, sel_hi_q}));

    // R6
    fw_inphase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && (sel_lo_q || sel_hi_q)) |-> ((drv_ua == drv_la) && (drv_ub == drv_lb)));

endmodule

bind fwb_drive_ctrl fwb_drive_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .uv_in      (uv_in),
    .phase_rise (phase_rise),
    .en_q       (en_q),
    .oc_hold_q  (oc_hold_q),
    .sel_lo_q   (sel_lo_q),
    .sel_hi_q   (sel_hi_q),
    .drv_ua     (drv_ua),
    .drv_ub     (drv_ub),
    .drv_la     (drv_la),
    .drv_lb     (drv_lb)
);

// File: tb/fwb_drive_ctrl_bench.sv
`timescale 1ns/1ps
// Bench: directed scenarios for fwb_drive_ctrl, one task each.
// Inputs change and outputs are sampled on falling clock edges.
module fwb_drive_ctrl_bench;

    localparam int HALF = 8;   // clocks per phase half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic phase_in = 1'b0;
    logic burst_in = 1'b0;
    logic oc_in = 1'b0;
    logic uv_in = 1'b0;
    logic drv_ua, drv_ub, drv_la, drv_lb;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    fwb_drive_ctrl u_fwb_drive_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_in (phase_in),
        .burst_in (burst_in),
        .oc_in    (oc_in),
        .uv_in    (uv_in),
        .drv_ua   (drv_ua),
        .drv_ub   (drv_ub),
        .drv_la   (drv_la),
        .drv_lb   (drv_lb)
    );

    // Expected patterns {ua,ub,la,lb} for a given delayed phase value.
    function automatic logic [3:0] pat_norm(input logic v);
        return {v, ~v, ~v, v};
    endfunction
    function automatic logic [3:0] pat_lo(input logic v);
        return {v, ~v, v, ~v};
    endfunction
    function automatic logic [3:0] pat_hi(input logic v);
        return {~v, v, ~v, v};
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {drv_ua, drv_ub, drv_la, drv_lb};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One phase half period, optionally with an over-current pulse mid-half.
    task automatic half(input logic v, input logic with_oc,
                        input logic [3:0] exp, input string tag);
        phase_in = v;
        if (with_oc) begin
            repeat (3) @(negedge clk);
            oc_in = 1'b1;
            repeat (2) @(negedge clk);
            oc_in = 1'b0;
            check(exp, {tag, " mid-half"});
            repeat (HALF - 5) @(negedge clk);
        end else begin
            repeat (HALF) @(negedge clk);
        end
        check(exp, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(4'b0000, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(4'b0000, "R1 after reset");
    endtask

    task automatic t_idle;
        half(1'b1, 1'b0, 4'b0000, "R2 idle high");
        half(1'b0, 1'b1, 4'b0000, "R2 idle low with oc");
        half(1'b1, 1'b0, 4'b0000, "R2 idle high again");
        half(1'b0, 1'b0, 4'b0000, "R2 idle low again");
    endtask

    task automatic t_start;
        burst_in = 1'b1;
        half(1'b0, 1'b0, 4'b0000,        "R4 no drive before phase rise");
        half(1'b1, 1'b0, pat_norm(1'b1), "R3 R4 first high half");
        half(1'b0, 1'b0, pat_norm(1'b0), "R3 R10 first low half");
    endtask

    task automatic t_latency;
        phase_in = 1'b1;
        repeat (2) @(negedge clk);
        check(pat_norm(1'b0), "R9 unchanged after two clocks");
        @(negedge clk);
        check(pat_norm(1'b1), "R9 changed on third clock");
        repeat (HALF - 3) @(negedge clk);
        half(1'b0, 1'b0, pat_norm(1'b0), "R9 low half");
    endtask

    task automatic t_oc_alt;
        half(1'b1, 1'b1, pat_norm(1'b1), "R5 oc held, period unchanged");
        half(1'b0, 1'b0, pat_norm(1'b0), "R5 low half still normal");
        half(1'b1, 1'b0, pat_lo(1'b1),   "R6 first event lower pair high");
        half(1'b0, 1'b0, pat_lo(1'b0),   "R6 first event lower pair low");
        half(1'b1, 1'b0, pat_norm(1'b1), "R5 freewheel lasts one period");
        half(1'b0, 1'b0, pat_norm(1'b0), "R5 back to normal low");
        half(1'b1, 1'b1, pat_norm(1'b1), "R5 second oc held");
        half(1'b0, 1'b0, pat_norm(1'b0), "R5 second oc low half");
        half(1'b1, 1'b0, pat_hi(1'b1),   "R6 second event upper pair high");
        half(1'b0, 1'b0, pat_hi(1'b0),   "R6 second event upper pair low");
        half(1'b1, 1'b0, pat_norm(1'b1), "R5 normal after second event");
        half(1'b0, 1'b0, pat_norm(1'b0), "R3 normal low");
    endtask

    task automatic t_stop_fw;
        half(1'b1, 1'b1, pat_norm(1'b1), "R5 third oc held");
        half(1'b0, 1'b0, pat_norm(1'b0), "R5 third oc low half");
        half(1'b1, 1'b0, pat_lo(1'b1),   "R6 third event lower pair");
        burst_in = 1'b0;
        half(1'b0, 1'b0, pat_lo(1'b0),   "R4 freewheel holds until phase rise");
        half(1'b1, 1'b0, 4'b0000,        "R4 quiescent after burst end");
        half(1'b0, 1'b0, 4'b0000,        "R4 no in-phase toggling low");
        half(1'b1, 1'b0, 4'b0000,        "R4 no in-phase toggling high");
    endtask

    task automatic t_preset;
        burst_in = 1'b1;
        half(1'b0, 1'b1, 4'b0000,        "R7 oc before burst start");
        half(1'b1, 1'b0, pat_norm(1'b1), "R7 burst starts in normal drive");
        half(1'b0, 1'b0, pat_norm(1'b0), "R7 normal low");
        half(1'b1, 1'b0, pat_norm(1'b1), "R7 discarded oc not carried");
        half(1'b0, 1'b0, pat_norm(1'b0), "R7 normal low again");
        half(1'b1, 1'b1, pat_norm(1'b1), "R7 fresh oc held");
        half(1'b0, 1'b0, pat_norm(1'b0), "R7 fresh oc low half");
        half(1'b1, 1'b0, pat_hi(1'b1),   "R7 discarded oc did not advance leg");
        half(1'b0, 1'b0, pat_hi(1'b0),   "R6 fourth event upper pair low");
        half(1'b1, 1'b0, pat_norm(1'b1), "R3 normal high");
        half(1'b0, 1'b0, pat_norm(1'b0), "R3 normal low");
    endtask

    task automatic t_uv_mid;
        phase_in = 1'b1;
        repeat (3) @(negedge clk);
        check(pat_norm(1'b1), "R8 driving before uv");
        uv_in = 1'b1;
        #1;
        check(4'b0000, "R8 immediate clear");
        repeat (2) @(negedge clk);
        uv_in = 1'b0;
        repeat (HALF - 5) @(negedge clk);
        check(4'b0000, "R8 off after uv release");
        half(1'b0, 1'b0, 4'b0000,        "R8 stays off low");
        half(1'b1, 1'b0, 4'b0000,        "R8 stays off through phase rise");
        burst_in = 1'b0;
        half(1'b0, 1'b0, 4'b0000,        "R8 burst low");
        half(1'b1, 1'b0, 4'b0000,        "R8 burst low high half");
        burst_in = 1'b1;
        half(1'b0, 1'b0, 4'b0000,        "R8 new burst before phase rise");
        half(1'b1, 1'b0, pat_norm(1'b1), "R8 resumes on new burst");
        half(1'b0, 1'b0, pat_norm(1'b0), "R8 resumed low");
    endtask

    task automatic t_uv_override;
        burst_in = 1'b0;
        half(1'b1, 1'b0, pat_norm(1'b1), "R4 still on until next rise");
        half(1'b0, 1'b0, pat_norm(1'b0), "R4 still on low");
        half(1'b1, 1'b0, 4'b0000,        "R4 off after rise");
        uv_in = 1'b1;
        burst_in = 1'b1;
        phase_in = 1'b0;
        repeat (6) @(negedge clk);
        uv_in = 1'b0;
        repeat (HALF - 6) @(negedge clk);
        check(4'b0000, "R8 burst rise under uv");
        half(1'b1, 1'b0, 4'b0000,        "R8 clear overrides set");
        half(1'b0, 1'b0, 4'b0000,        "R8 override low");
        half(1'b1, 1'b0, 4'b0000,        "R8 override high");
        burst_in = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle();
        t_start();
        t_latency();
        t_oc_alt();
        t_stop_fw();
        t_preset();
        t_uv_mid();
        t_uv_override();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (R1..) actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule